// File: doc/BRIEF.md
# Legacy IO Cycle Routing Decoder

This block sits on the host side of a bridge. For each processor cycle it picks where the cycle goes: the graphics port (AGP) or the primary PCI bus. A cycle may also be left unclaimed. IO cycles are routed through a layered set of checks: the monochrome-adapter port carve-out, then VGA forwarding, then ISA alias masking, then a programmable graphics IO window. Every legacy check looks only at the low ten address bits, so each 1 KB alias behaves the same. Memory cycles that fall in the legacy video memory window are routed under the same VGA and monochrome controls.

One request is presented per clock, with a valid bit, a memory/IO select, a processor-initiator flag and an address. The configuration inputs are held static by the surrounding bridge. The decision is captured in a small route state register, and the registered valid and one-hot route appear one clock later. The register has four states. ST_IDLE means no request was seen. ST_AGP, ST_PCI and ST_DROP each mean the last request was routed that way. On every clock edge the register moves from any state to ST_IDLE when no request is valid. Otherwise it moves to the state that the priority decision selects. Synchronous reset forces ST_IDLE.

Top module: `legio_route_decoder`

## Requirements
- R1: The output valid equals the request valid of the previous clock. The route is 3'b000 whenever the output valid is low. A synchronous reset clears both outputs at the next edge.
- R2: A valid request with the processor-initiator flag low routes to unclaimed (route 3'b100), whether it is memory or IO.
- R3: With the VGA enable set, a processor IO cycle whose address bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh routes to AGP (route 3'b001). This holds whatever the ISA enable and window settings are, and address bits 15:10 are ignored. The only exception is the case R4 names.
- R4: With both the VGA enable and the monochrome bit set, processor IO cycles whose bits 9:0 equal 3B4h, 3B5h, 3B8h, 3B9h, 3BAh or 3BFh route to PCI (route 3'b010). When the VGA enable is clear, the monochrome bit has no effect on any route.
- R5: With the ISA enable set, a processor IO cycle that is not taken by R3 or R4 and has address bits 9:8 not equal to 00 routes to PCI, even inside the AGP IO window.
- R6: A processor IO cycle not taken by R3–R5 routes to AGP when address bits 15:12 lie between base bits 15:12 and limit bits 15:12, inclusive at both ends. When the limit block is below the base block, the window matches nothing.
- R7: Any other processor IO cycle routes to PCI.
- R8: A processor memory cycle in A0000h–BFFFFh (all higher address bits zero) routes as follows. With the VGA enable set it goes to AGP, except that B0000h–B7FFFh goes to PCI when the monochrome bit is also set. With the VGA enable clear it goes to PCI. Memory cycles outside that window are unclaimed.
- R9: Whenever the output valid is high, exactly one route bit is set. Bit 0 is AGP, bit 1 is PCI and bit 2 is unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_mem | input | 1 | 1 = memory cycle, 0 = IO cycle |
| req_cpu | input | 1 | 1 = started by the processor |
| req_addr | input | ADDR_W | Cycle address; IO cycles use bits 15:0 |
| cfg_vga_en | input | 1 | Forward VGA ranges to AGP |
| cfg_isa_en | input | 1 | Send the upper 768 bytes of each 1 KB block to PCI |
| cfg_mono_en | input | 1 | A monochrome adapter lives on PCI |
| cfg_io_base | input | IO_AW | AGP IO window base (bits 15:12 used) |
| cfg_io_limit | input | IO_AW | AGP IO window limit (bits 15:12 used) |
| out_valid | output | 1 | Registered decision valid |
| out_route | output | 3 | One-hot route: bit0 AGP, bit1 PCI, bit2 unclaimed |

## Verification
The bench builds the block with its defaults: a 16-bit IO space, a 10-bit alias field and 4 KB window granularity. These are small enough that all 1024 alias offsets can be swept under all eight combinations of the VGA, ISA and monochrome bits, with the upper alias bits varied on every step. All 256 base/limit pairs are crossed with every 4 KB block, both with the ISA enable clear and set, which covers the inverted-window and single-block cases. A stepped sweep of the memory range around the video window, plus its exact edges, checks the monochrome sub-range and the unclaimed region.

// File: rtl/legio_pkg.sv
`timescale 1ns/1ps
package legio_pkg;

    // Route register states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AGP  = 2'd1,
        ST_PCI  = 2'd2,
        ST_DROP = 2'd3
    } rt_state_t;

    localparam int RT_W = 3;

    localparam logic [RT_W-1:0] ROUTE_NONE = 3'b000;
    localparam logic [RT_W-1:0] ROUTE_AGP  = 3'b001;
    localparam logic [RT_W-1:0] ROUTE_PCI  = 3'b010;
    localparam logic [RT_W-1:0] ROUTE_DROP = 3'b100;

endpackage

// File: rtl/legio_vga_match.sv
`timescale 1ns/1ps
// Legacy VGA / monochrome port match on the alias field only.
module legio_vga_match #(
    parameter int ALIAS_W = 10,
    parameter logic [ALIAS_W-1:0] VGA_A_LO = 10'h3B0,
    parameter logic [ALIAS_W-1:0] VGA_A_HI = 10'h3BB,
    parameter logic [ALIAS_W-1:0] VGA_B_LO = 10'h3C0,
    parameter logic [ALIAS_W-1:0] VGA_B_HI = 10'h3DF,
    parameter int MONO_N = 6,
    parameter logic [MONO_N-1:0][ALIAS_W-1:0] MONO_PORTS =
        {10'h3BF, 10'h3BA, 10'h3B9, 10'h3B8, 10'h3B5, 10'h3B4}
) (
    input  logic [ALIAS_W-1:0] alias_addr,
    output logic               vga_hit,
    output logic               mono_hit
);

    logic [MONO_N-1:0] mono_eq;

    for (genvar g = 0; g < MONO_N; g++) begin : g_mono
        assign mono_eq[g] = (alias_addr == MONO_PORTS[g]);
    end

    assign mono_hit = |mono_eq;

    always_comb begin
        vga_hit = ((alias_addr >= VGA_A_LO) && (alias_addr <= VGA_A_HI)) ||
                  ((alias_addr >= VGA_B_LO) && (alias_addr <= VGA_B_HI));
    end

endmodule

// File: rtl/legio_io_window.sv
`timescale 1ns/1ps
// Block-granular base/limit compare for the graphics IO window.
module legio_io_window #(
    parameter int IO_AW    = 16,
    parameter int GRAN_LSB = 12
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_AW-1:0] io_base,
    input  logic [IO_AW-1:0] io_limit,
    output logic             in_win
);

    localparam int BLK_W = IO_AW - GRAN_LSB;

    logic [BLK_W-1:0] blk_addr;
    logic [BLK_W-1:0] blk_base;
    logic [BLK_W-1:0] blk_lim;
    logic             win_on;
    logic             unused_low;

    assign blk_addr = io_addr[IO_AW-1:GRAN_LSB];
    assign blk_base = io_base[IO_AW-1:GRAN_LSB];
    assign blk_lim  = io_limit[IO_AW-1:GRAN_LSB];

    assign unused_low = ^{io_addr[GRAN_LSB-1:0], io_base[GRAN_LSB-1:0],
                          io_limit[GRAN_LSB-1:0]};

    always_comb begin
        win_on = (blk_lim >= blk_base);
        in_win = win_on && (blk_addr >= blk_base) && (blk_addr <= blk_lim);
    end

endmodule

// File: rtl/legio_mem_window.sv
`timescale 1ns/1ps
// Legacy video memory window and its monochrome sub-range.
module legio_mem_window #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] VID_LO  = 'h000A_0000,
    parameter logic [ADDR_W-1:0] VID_HI  = 'h000B_FFFF,
    parameter logic [ADDR_W-1:0] MONO_LO = 'h000B_0000,
    parameter logic [ADDR_W-1:0] MONO_HI = 'h000B_7FFF
) (
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              vid_hit,
    output logic              mono_hit
);

    always_comb begin
        vid_hit  = (mem_addr >= VID_LO)  && (mem_addr <= VID_HI);
        mono_hit = (mem_addr >= MONO_LO) && (mem_addr <= MONO_HI);
    end

endmodule

// File: rtl/legio_route_decoder.sv
`timescale 1ns/1ps
// Processor cycle routing decoder: AGP, PCI or unclaimed, one clock latency.
module legio_route_decoder
    import legio_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IO_AW    = 16,
    parameter int ALIAS_W  = 10,
    parameter int GRAN_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_mem,
    input  logic              req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_vga_en,
    input  logic              cfg_isa_en,
    input  logic              cfg_mono_en,
    input  logic [IO_AW-1:0]  cfg_io_base,
    input  logic [IO_AW-1:0]  cfg_io_limit,
    output logic              out_valid,
    output logic [RT_W-1:0]   out_route
);

    localparam int ISA_HI = ALIAS_W - 1;
    localparam int ISA_LO = ALIAS_W - 2;

    logic [IO_AW-1:0]   io_addr;
    logic [ALIAS_W-1:0] alias_addr;
    logic               io_vga;
    logic               io_mono;
    logic               io_in_win;
    logic               isa_upper;
    logic               mem_vid;
    logic               mem_mono;

    rt_state_t state_q;
    rt_state_t state_nxt;

    assign io_addr    = req_addr[IO_AW-1:0];
    assign alias_addr = req_addr[ALIAS_W-1:0];
    assign isa_upper  = |req_addr[ISA_HI:ISA_LO];

    legio_vga_match #(
        .ALIAS_W (ALIAS_W)
    ) u_vga (
        .alias_addr (alias_addr),
        .vga_hit    (io_vga),
        .mono_hit   (io_mono)
    );

    legio_io_window #(
        .IO_AW    (IO_AW),
        .GRAN_LSB (GRAN_LSB)
    ) u_win (
        .io_addr  (io_addr),
        .io_base  (cfg_io_base),
        .io_limit (cfg_io_limit),
        .in_win   (io_in_win)
    );

    legio_mem_window #(
        .ADDR_W (ADDR_W)
    ) u_mem (
        .mem_addr (req_addr),
        .vid_hit  (mem_vid),
        .mono_hit (mem_mono)
    );

    // Priority decision: next route state
    always_comb begin
        state_nxt = ST_IDLE;
        if (req_valid) begin
            if (!req_cpu) begin
                state_nxt = ST_DROP;
            end else if (req_mem) begin
                if (!mem_vid) begin
                    state_nxt = ST_DROP;
                end else if (cfg_vga_en && cfg_mono_en && mem_mono) begin
                    state_nxt = ST_PCI;
                end else if (cfg_vga_en) begin
                    state_nxt = ST_AGP;
                end else begin
                    state_nxt = ST_PCI;
                end
            end else if (cfg_vga_en && cfg_mono_en && io_mono) begin
                state_nxt = ST_PCI;
            end else if (cfg_vga_en && io_vga) begin
                state_nxt = ST_AGP;
            end else if (cfg_isa_en && isa_upper) begin
                state_nxt = ST_PCI;
            end else if (io_in_win) begin
                state_nxt = ST_AGP;
            end else begin
                state_nxt = ST_PCI;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Outputs from the registered state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin out_valid = 1'b0; out_route = ROUTE_NONE; end
            ST_AGP:  begin out_valid = 1'b1; out_route = ROUTE_AGP;  end
            ST_PCI:  begin out_valid = 1'b1; out_route = ROUTE_PCI;  end
            ST_DROP: begin out_valid = 1'b1; out_route = ROUTE_DROP; end
            default: begin out_valid = 1'b0; out_route = ROUTE_NONE; end
        endcase
    end

endmodule

// File: rtl/legio_route_chk.sv
`timescale 1ns/1ps
module legio_route_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_mem,
    input logic              req_cpu,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cfg_vga_en,
    input logic              cfg_isa_en,
    input logic              out_valid,
    input logic [2:0]        out_route
);

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && out_route == 3'b000));

    // R9
    onehot_route_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_route) == 1));

    // R2
    noncpu_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_cpu) |=> (out_route == 3'b100));

    // R3
    vga_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cpu && !req_mem && cfg_vga_en &&
         req_addr[9:5] == 5'b11110) |=> (out_route == 3'b001));

    // R5
    isa_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cpu && !req_mem && !cfg_vga_en && cfg_isa_en &&
         req_addr[9:8] != 2'b00) |=> (out_route == 3'b010));

endmodule

bind legio_route_decoder legio_route_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mem    (req_mem),
    .req_cpu    (req_cpu),
    .req_addr   (req_addr),
    .cfg_vga_en (cfg_vga_en),
    .cfg_isa_en (cfg_isa_en),
    .out_valid  (out_valid),
    .out_route  (out_route)
);

// File: tb/sim_legio_route_decoder.sv
`timescale 1ns/1ps
module sim_legio_route_decoder;

    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_cpu = 1'b0;
    logic [31:0] req_addr = '0;
    logic        cfg_vga_en = 1'b0;
    logic        cfg_isa_en = 1'b0;
    logic        cfg_mono_en = 1'b0;
    logic [15:0] cfg_io_base = '0;
    logic [15:0] cfg_io_limit = '0;
    logic        out_valid;
    logic [2:0]  out_route;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    legio_route_decoder u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mem(req_mem),
        .req_cpu(req_cpu), .req_addr(req_addr), .cfg_vga_en(cfg_vga_en),
        .cfg_isa_en(cfg_isa_en), .cfg_mono_en(cfg_mono_en),
        .cfg_io_base(cfg_io_base), .cfg_io_limit(cfg_io_limit),
        .out_valid(out_valid), .out_route(out_route)
    );

    // Expected IO route from the requirements
    function automatic logic [2:0] exp_io(input logic [15:0] a, input logic vga,
        input logic isa, input logic mono, input logic [15:0] b,
        input logic [15:0] l, output string tag);
        int lo, blk, bb, lb;
        bit is_mono, is_vga;
        lo  = int'(a[9:0]);
        blk = int'(a[15:12]);
        bb  = int'(b[15:12]);
        lb  = int'(l[15:12]);
        is_mono = (lo == 'h3B4) || (lo == 'h3B5) || (lo == 'h3B8) ||
                  (lo == 'h3B9) || (lo == 'h3BA) || (lo == 'h3BF);
        is_vga  = (lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF);
        if (vga && mono && is_mono) begin tag = "R4"; return 3'b010; end
        if (vga && is_vga) begin tag = "R3"; return 3'b001; end
        if (isa && (lo >= 256)) begin tag = "R5"; return 3'b010; end
        if (lb >= bb && blk >= bb && blk <= lb) begin tag = "R6"; return 3'b001; end
        tag = "R7";
        return 3'b010;
    endfunction

    // Expected memory route from the requirements
    function automatic logic [2:0] exp_mem(input logic [31:0] a, input logic vga,
        input logic mono, output string tag);
        tag = "R8";
        if (a < 32'hA0000 || a > 32'hBFFFF) return 3'b100;
        if (vga && mono && a >= 32'hB0000 && a <= 32'hB7FFF) return 3'b010;
        if (vga) return 3'b001;
        return 3'b010;
    endfunction

    task automatic check(input logic exp_v, input logic [2:0] exp_r, input string tag);
        n_chk++;
        if (out_valid !== exp_v || out_route !== exp_r) begin
            n_bad++;
            $display("FAIL %s addr=%h act v=%b r=%b exp v=%b r=%b", tag, req_addr,
                     out_valid, out_route, exp_v, exp_r);
        end
    endtask

    // Inputs are set at a negedge; the result is sampled at the next negedge.
    task automatic apply(input logic v, input logic mem, input logic cpu,
        input logic [31:0] a, input logic [2:0] exp_r, input string tag);
        req_valid = v; req_mem = mem; req_cpu = cpu; req_addr = a;
        @(negedge clk);
        check(v, exp_r, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        string tg;
        logic [2:0] er;
        logic [15:0] a16;
        repeat (3) @(negedge clk);
        check(1'b0, 3'b000, "R1 reset");
        rst = 1'b0;
        // R1 idle after reset
        apply(1'b0, 1'b0, 1'b1, 32'h3C0, 3'b000, "R1 idle");

        // IO sweep over all alias offsets and configs
        cfg_io_base = 16'h4000; cfg_io_limit = 16'h7FFF;
        for (int cfg = 0; cfg < 8; cfg++) begin
            cfg_vga_en = cfg[0]; cfg_isa_en = cfg[1]; cfg_mono_en = cfg[2];
            for (int lo = 0; lo < 1024; lo++) begin
                a16 = {6'((lo * 7 + cfg * 13) & 63), 10'(lo)};
                er = exp_io(a16, cfg_vga_en, cfg_isa_en, cfg_mono_en,
                            cfg_io_base, cfg_io_limit, tg);
                apply(1'b1, 1'b0, 1'b1, {16'hA5A5, a16}, er, tg);
                if ((lo % 97) == 0) apply(1'b0, 1'b0, 1'b1, 32'h0, 3'b000, "R1 gap");
            end
        end

        // Window sweep: every base, limit and block
        cfg_vga_en = 1'b0; cfg_mono_en = 1'b1;
        for (int isa = 0; isa < 2; isa++) begin
            cfg_isa_en = isa[0];
            for (int b = 0; b < 16; b++) begin
                for (int l = 0; l < 16; l++) begin
                    cfg_io_base = {4'(b), 12'h000}; cfg_io_limit = {4'(l), 12'hFFF};
                    for (int blk = 0; blk < 16; blk++) begin
                        a16 = {4'(blk), 2'(blk + l), 10'h0F0};
                        if (isa == 1 && blk[0]) a16[9:8] = 2'(blk[2:1] | 2'b01);
                        er = exp_io(a16, 1'b0, cfg_isa_en, 1'b1,
                                    cfg_io_base, cfg_io_limit, tg);
                        apply(1'b1, 1'b0, 1'b1, {16'h0, a16}, er, tg);
                    end
                end
            end
        end

        // Non-processor initiators are unclaimed
        cfg_vga_en = 1'b1; cfg_isa_en = 1'b1; cfg_io_base = 16'h0; cfg_io_limit = 16'hFFFF;
        apply(1'b1, 1'b0, 1'b0, 32'h3C0, 3'b100, "R2 io vga");
        apply(1'b1, 1'b0, 1'b0, 32'h1100, 3'b100, "R2 io window");
        apply(1'b1, 1'b1, 1'b0, 32'hA8000, 3'b100, "R2 mem video");
        apply(1'b1, 1'b1, 1'b0, 32'h0, 3'b100, "R2 mem low");

        // Memory sweep around the video window plus edges
        for (int cfg = 0; cfg < 4; cfg++) begin
            cfg_vga_en = cfg[0]; cfg_mono_en = cfg[1];
            for (int i = 0; i < 56; i++) begin
                logic [31:0] ma;
                ma = 32'h90000 + 32'(i) * 32'h800;
                er = exp_mem(ma, cfg_vga_en, cfg_mono_en, tg);
                apply(1'b1, 1'b1, 1'b1, ma, er, tg);
            end
            foreach (edge_list[k]) begin
                er = exp_mem(edge_list[k], cfg_vga_en, cfg_mono_en, tg);
                apply(1'b1, 1'b1, 1'b1, edge_list[k], er, tg);
            end
        end

        // R9 and R1: reset mid-stream clears outputs
        apply(1'b1, 1'b1, 1'b1, 32'hA0000, exp_mem(32'hA0000, cfg_vga_en, cfg_mono_en, tg), "R9");
        rst = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        check(1'b0, 3'b000, "R1 reset mid");
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    logic [31:0] edge_list [8] = '{32'h9FFFF, 32'hA0000, 32'hAFFFF, 32'hB0000,
                                   32'hB7FFF, 32'hB8000, 32'hBFFFF, 32'h1A0000};

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1 watchdog act=timeout exp=completion");
            summary();
            $finish;
        end
    end

endmodule